// File: doc/BRIEF.md
# Word-Ownership Private Data Cache Controller

This block is a small direct-mapped private data cache that sits between one core and a shared last-level cache (LLC). Coherence rests on a data-race-free programming model. Each word of each line is in one of three stable states: Invalid, Valid or Owned.

A store does not write through. It registers the cache as owner of that word at the LLC, and the data then stays local. At every synchronizing access (acquire or release), the cache drops all of its Valid words on its own. Owned words keep their state and data through the sync. This makes stale copies the reader's concern. The controller keeps no sharer lists, sends no invalidations and waits for no acknowledgements.

The LLC may forward a read for a word this cache owns. The cache answers from its local copy and stays owner. When a line is evicted, each Owned word in it is written back, which hands its ownership back to the LLC. Only one LLC transaction is in flight at a time, and the core port stalls until it completes.

Top module: `l1own_cache`

## Requirements
- R1: After reset every word is Invalid, `core_ready` is 1 and `llc_req_valid` is 0, so the first access to any word misses.
- R2: A load (core op 0) to an Invalid word issues exactly one LLC request with op 0 (read) for that word address, returns the LLC data on `core_rdata` with `core_done`, and leaves the word Valid. A later load to it issues no request and returns the cached value.
- R3: A store (core op 1) to a word that is not Owned issues exactly one LLC request with op 1 (take ownership) for that word and marks it Owned. Stores and loads to an Owned word issue no LLC request, and no store is ever written through.
- R4: An acquire (core op 2) or release (core op 3) first turns every Valid word in the whole cache Invalid. A stale Valid copy is therefore refetched on its next load, while Owned words keep their state and data.
- R5: An acquire or release to a word the cache already owns completes locally with no LLC request. An acquire returns the owned data, and a release overwrites it.
- R6: A synchronizing access never causes a writeback (LLC op 2) of Owned data that lives in lines other than the one it addresses.
- R7: An access whose tag differs from the resident tag of its set first writes back each Owned word of the resident line with LLC op 2, carrying that word's address and data, lowest word first. The access then proceeds as a miss.
- R8: A forwarded read (`fwd_valid`) is answered one cycle later with `fwd_rsp_valid`. `fwd_rsp_hit` is 1 with the cached data when the word is Owned here, and 0 otherwise. The word stays Owned.
- R9: At most one LLC request is outstanding. `core_ready` is 0 from the cycle after a request is accepted until the cycle `core_done` pulses, and `llc_req_valid` pulses for one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_valid | input | 1 | Core request strobe, taken when `core_ready` is 1 |
| core_op | input | 2 | 0 load, 1 store, 2 acquire, 3 release |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | DATA_W | Store / release data |
| core_ready | output | 1 | Controller idle and able to take a request |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Load / acquire result, valid with `core_done` |
| llc_req_valid | output | 1 | One-cycle LLC request pulse |
| llc_req_op | output | 2 | 0 read, 1 take ownership, 2 writeback and release ownership |
| llc_req_addr | output | ADDR_W | Word address of the request |
| llc_req_data | output | DATA_W | Writeback data |
| llc_resp_valid | input | 1 | LLC completion of the outstanding request |
| llc_resp_data | input | DATA_W | Read data from the LLC |
| fwd_valid | input | 1 | LLC forwards a read to this cache |
| fwd_addr | input | ADDR_W | Word address of the forwarded read |
| fwd_rsp_valid | output | 1 | Answer to a forwarded read |
| fwd_rsp_hit | output | 1 | Word was Owned here |
| fwd_rsp_data | output | DATA_W | Owned data when hit |

## Verification
The bench builds the cache with 8-bit word addresses, 16-bit data, two words per line and four sets, and draws addresses from only 32 words. With four tags competing for every set, evictions of lines that hold one or two Owned words happen often, and so do writebacks in lowest-word order. Acquires and releases are mixed in with external updates to LLC memory on words that are not owned. This shows stale Valid reads before a sync and fresh reads after it. At the end, the LLC contents are compared with the written-back values the model expects.

// File: rtl/l1own_pkg.sv
package l1own_pkg;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_ACQ = 2'd2, OP_REL = 2'd3} core_op_e;
  typedef enum logic [1:0] {LLC_READ = 2'd0, LLC_OWN = 2'd1, LLC_WB = 2'd2} llc_op_e;
  localparam logic [1:0] WS_INV = 2'd0;
  localparam logic [1:0] WS_VAL = 2'd1;
  localparam logic [1:0] WS_OWN = 2'd2;
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_WAIT_WB, S_WAIT_RD, S_WAIT_OWN} ctrl_state_e;
endpackage

// File: rtl/l1own_dram.sv
module l1own_dram #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/l1own_tagstate.sv
module l1own_tagstate
  import l1own_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WORDS = 2,
  parameter int TAG_W = 5,
  localparam int SET_W = $clog2(SETS),
  localparam int WO_W  = $clog2(WORDS),
  localparam int ENTRIES = SETS * WORDS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_i,
  input  logic             tag_wr,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             st_wr,
  input  logic [WO_W-1:0]  st_word,
  input  logic [1:0]       st_val,
  input  logic             sync_clr,
  output logic [TAG_W-1:0] tag_o,
  output logic [1:0]       st_o [WORDS],
  input  logic [SET_W-1:0] fwd_set,
  input  logic [WO_W-1:0]  fwd_word,
  output logic [TAG_W-1:0] fwd_tag_o,
  output logic [1:0]       fwd_st_o
);
  logic [TAG_W-1:0] tag_q [SETS];
  logic [1:0]       st_q  [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
    end else if (tag_wr) begin
      tag_q[set_i] <= tag_i;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_word
    localparam int SG = g / WORDS;
    always_ff @(posedge clk) begin
      if (rst) st_q[g] <= WS_INV;
      else if (tag_wr && set_i == SET_W'(SG)) st_q[g] <= WS_INV;
      else if (st_wr && {set_i, st_word} == (SET_W + WO_W)'(g)) st_q[g] <= st_val;
      else if (sync_clr && st_q[g] == WS_VAL) st_q[g] <= WS_INV;
    end

    AST_SYNC_KEEPS_OWNED: assert property (@(posedge clk) disable iff (rst)
      (sync_clr && st_q[g] == WS_OWN) |=> st_q[g] == WS_OWN); // R4
    AST_SYNC_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
      (sync_clr && st_q[g] == WS_VAL) |=> st_q[g] == WS_INV); // R4
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_rd
    assign st_o[w] = st_q[{set_i, WO_W'(w)}];
  end

  assign tag_o     = tag_q[set_i];
  assign fwd_tag_o = tag_q[fwd_set];
  assign fwd_st_o  = st_q[{fwd_set, fwd_word}];
endmodule

// File: rtl/l1own_cache.sv
module l1own_cache
  import l1own_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int WORDS_LOG2 = 1,
  parameter int SETS_LOG2  = 2,
  localparam int WORDS = 1 << WORDS_LOG2,
  localparam int SETS  = 1 << SETS_LOG2,
  localparam int TAG_W = ADDR_W - SETS_LOG2 - WORDS_LOG2,
  localparam int IDX_W = SETS_LOG2 + WORDS_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_valid,
  input  logic [1:0]        core_op,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ready,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  output logic              llc_req_valid,
  output logic [1:0]        llc_req_op,
  output logic [ADDR_W-1:0] llc_req_addr,
  output logic [DATA_W-1:0] llc_req_data,
  input  logic              llc_resp_valid,
  input  logic [DATA_W-1:0] llc_resp_data,
  input  logic              fwd_valid,
  input  logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_rsp_valid,
  output logic              fwd_rsp_hit,
  output logic [DATA_W-1:0] fwd_rsp_data
);
  ctrl_state_e state_q;
  core_op_e    op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic [WORDS_LOG2-1:0] r_word;
  logic [SETS_LOG2-1:0]  r_set;
  logic [TAG_W-1:0]      r_tag;
  assign r_word = addr_q[WORDS_LOG2-1:0];
  assign r_set  = addr_q[WORDS_LOG2 +: SETS_LOG2];
  assign r_tag  = addr_q[ADDR_W-1 -: TAG_W];

  logic [TAG_W-1:0] tag_rd, fwd_tag;
  logic [1:0]       st_rd [WORDS];
  logic [1:0]       fwd_st, cur_st;
  logic             tag_wr, st_wr, sync_clr, dram_we;
  logic [WORDS_LOG2-1:0] st_word, own_idx;
  logic [1:0]       st_val;
  logic [IDX_W-1:0] dram_waddr, dram_raddr;
  logic [DATA_W-1:0] dram_wdata, dram_rdata, fwd_rdata;
  logic tag_hit, any_own, is_load;

  assign cur_st  = st_rd[r_word];
  assign tag_hit = (tag_rd == r_tag);
  assign is_load = (op_q == OP_LOAD) || (op_q == OP_ACQ);

  always_comb begin
    any_own = 1'b0;
    own_idx = '0;
    for (int w = WORDS - 1; w >= 0; w--) begin
      if (st_rd[w] == WS_OWN) begin
        any_own = 1'b1;
        own_idx = WORDS_LOG2'(w);
      end
    end
  end

  assign sync_clr = (state_q == S_IDLE) && core_valid && core_op[1];
  assign tag_wr   = (state_q == S_CHECK) && !tag_hit && !any_own;

  always_comb begin
    st_wr      = 1'b0;
    st_word    = r_word;
    st_val     = WS_INV;
    dram_we    = 1'b0;
    dram_wdata = wdata_q;
    dram_raddr = {r_set, r_word};
    case (state_q)
      S_CHECK: begin
        if (!tag_hit && any_own) begin
          st_wr      = 1'b1;
          st_word    = own_idx;
          dram_raddr = {r_set, own_idx};
        end else if (tag_hit && !is_load && cur_st == WS_OWN) begin
          dram_we = 1'b1;
        end
      end
      S_WAIT_RD: if (llc_resp_valid) begin
        st_wr      = 1'b1;
        st_val     = WS_VAL;
        dram_we    = 1'b1;
        dram_wdata = llc_resp_data;
      end
      S_WAIT_OWN: if (llc_resp_valid) begin
        st_wr   = 1'b1;
        st_val  = WS_OWN;
        dram_we = 1'b1;
      end
      default: ;
    endcase
  end
  assign dram_waddr = {r_set, r_word};

  l1own_tagstate #(.SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W)) u_tagstate (
    .clk(clk), .rst(rst), .set_i(r_set), .tag_wr(tag_wr), .tag_i(r_tag),
    .st_wr(st_wr), .st_word(st_word), .st_val(st_val), .sync_clr(sync_clr),
    .tag_o(tag_rd), .st_o(st_rd),
    .fwd_set(fwd_addr[WORDS_LOG2 +: SETS_LOG2]), .fwd_word(fwd_addr[WORDS_LOG2-1:0]),
    .fwd_tag_o(fwd_tag), .fwd_st_o(fwd_st)
  );

  l1own_dram #(.DEPTH(SETS * WORDS), .DATA_W(DATA_W)) u_dram (
    .clk(clk), .we(dram_we), .waddr(dram_waddr), .wdata(dram_wdata),
    .raddr_a(dram_raddr), .rdata_a(dram_rdata),
    .raddr_b(fwd_addr[IDX_W-1:0]), .rdata_b(fwd_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_IDLE;
      op_q          <= OP_LOAD;
      addr_q        <= '0;
      wdata_q       <= '0;
      core_done     <= 1'b0;
      core_rdata    <= '0;
      llc_req_valid <= 1'b0;
      llc_req_op    <= LLC_READ;
      llc_req_addr  <= '0;
      llc_req_data  <= '0;
    end else begin
      core_done     <= 1'b0;
      llc_req_valid <= 1'b0;
      case (state_q)
        S_IDLE: if (core_valid) begin
          op_q    <= core_op_e'(core_op);
          addr_q  <= core_addr;
          wdata_q <= core_wdata;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          if (!tag_hit) begin
            if (any_own) begin
              llc_req_valid <= 1'b1;
              llc_req_op    <= LLC_WB;
              llc_req_addr  <= {tag_rd, r_set, own_idx};
              llc_req_data  <= dram_rdata;
              state_q       <= S_WAIT_WB;
            end
          end else if (is_load) begin
            if (cur_st != WS_INV) begin
              core_done  <= 1'b1;
              core_rdata <= dram_rdata;
              state_q    <= S_IDLE;
            end else begin
              llc_req_valid <= 1'b1;
              llc_req_op    <= LLC_READ;
              llc_req_addr  <= addr_q;
              state_q       <= S_WAIT_RD;
            end
          end else if (cur_st == WS_OWN) begin
            core_done  <= 1'b1;
            core_rdata <= '0;
            state_q    <= S_IDLE;
          end else begin
            llc_req_valid <= 1'b1;
            llc_req_op    <= LLC_OWN;
            llc_req_addr  <= addr_q;
            llc_req_data  <= wdata_q;
            state_q       <= S_WAIT_OWN;
          end
        end
        S_WAIT_WB: if (llc_resp_valid) state_q <= S_CHECK;
        S_WAIT_RD: if (llc_resp_valid) begin
          core_done  <= 1'b1;
          core_rdata <= llc_resp_data;
          state_q    <= S_IDLE;
        end
        S_WAIT_OWN: if (llc_resp_valid) begin
          core_done  <= 1'b1;
          core_rdata <= '0;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign core_ready = (state_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_rsp_valid <= 1'b0;
      fwd_rsp_hit   <= 1'b0;
      fwd_rsp_data  <= '0;
    end else begin
      fwd_rsp_valid <= fwd_valid;
      fwd_rsp_hit   <= fwd_valid && fwd_st == WS_OWN && fwd_tag == fwd_addr[ADDR_W-1 -: TAG_W];
      fwd_rsp_data  <= fwd_rdata;
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    llc_req_valid |=> !llc_req_valid); // R9
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (core_valid && core_ready) |=> !core_ready); // R9
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    core_ready |-> !llc_req_valid); // R9
  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    core_done |-> core_ready); // R9
  AST_FWD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |=> fwd_rsp_valid); // R8
endmodule

// File: tb/l1own_cache_tb.sv
module l1own_cache_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        core_valid = 1'b0;
  logic [1:0]  core_op = 2'd0;
  logic [7:0]  core_addr = '0;
  logic [15:0] core_wdata = '0;
  logic        core_ready, core_done;
  logic [15:0] core_rdata;
  logic        llc_req_valid;
  logic [1:0]  llc_req_op;
  logic [7:0]  llc_req_addr;
  logic [15:0] llc_req_data;
  logic        llc_resp_valid = 1'b0;
  logic [15:0] llc_resp_data = '0;
  logic        fwd_valid = 1'b0;
  logic [7:0]  fwd_addr = '0;
  logic        fwd_rsp_valid, fwd_rsp_hit;
  logic [15:0] fwd_rsp_data;

  l1own_cache #(.ADDR_W(8), .DATA_W(16), .WORDS_LOG2(1), .SETS_LOG2(2)) dut_i (
    .clk(clk), .rst(rst), .core_valid(core_valid), .core_op(core_op), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_ready(core_ready), .core_done(core_done), .core_rdata(core_rdata),
    .llc_req_valid(llc_req_valid), .llc_req_op(llc_req_op), .llc_req_addr(llc_req_addr),
    .llc_req_data(llc_req_data), .llc_resp_valid(llc_resp_valid), .llc_resp_data(llc_resp_data),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_rsp_valid(fwd_rsp_valid),
    .fwd_rsp_hit(fwd_rsp_hit), .fwd_rsp_data(fwd_rsp_data)
  );

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  int n_rd, n_own, n_wb;
  logic [7:0] last_wb_addr;

  logic [15:0] llc_mem [256];
  logic [15:0] ref_mem [256];
  logic [4:0]  m_tag [4];
  logic [1:0]  m_st  [8];
  logic [15:0] m_data [8];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // LLC responder: fixed two-cycle latency
  initial begin
    forever begin
      @(negedge clk);
      if (llc_req_valid) begin
        logic [7:0] a;
        a = llc_req_addr;
        case (llc_req_op)
          2'd0: n_rd++;
          2'd1: n_own++;
          default: begin n_wb++; last_wb_addr = a; llc_mem[a] = llc_req_data; end
        endcase
        @(negedge clk);
        @(negedge clk);
        llc_resp_data  = llc_mem[a];
        llc_resp_valid = 1'b1;
        @(negedge clk);
        llc_resp_valid = 1'b0;
      end
    end
  end

  function automatic bit model_owns(input logic [7:0] a);
    return m_tag[a[2:1]] == a[7:3] && m_st[a[2:0]] == 2'd2;
  endfunction

  task automatic poke(input logic [7:0] a, input logic [15:0] v);
    if (!model_owns(a)) begin
      llc_mem[a] = v;
      ref_mem[a] = v;
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d, input string rq);
    int e_rd, e_own, e_wb;
    logic [15:0] e_data;
    logic [1:0] s;
    e_rd = 0; e_own = 0; e_wb = 0; e_data = '0;
    s = a[2:1];
    if (op[1]) for (int i = 0; i < 8; i++) if (m_st[i] == 2'd1) m_st[i] = 2'd0;
    if (m_tag[s] != a[7:3]) begin
      for (int w = 0; w < 2; w++) if (m_st[{s, w[0]}] == 2'd2) begin
        e_wb++;
        ref_mem[{m_tag[s], s, w[0]}] = m_data[{s, w[0]}];
      end
      m_st[{s, 1'b0}] = 2'd0;
      m_st[{s, 1'b1}] = 2'd0;
      m_tag[s] = a[7:3];
    end
    if (op == 2'd0 || op == 2'd2) begin
      if (m_st[a[2:0]] == 2'd0) begin
        e_rd = 1;
        m_data[a[2:0]] = ref_mem[a];
        m_st[a[2:0]] = 2'd1;
      end
      e_data = m_data[a[2:0]];
    end else begin
      if (m_st[a[2:0]] != 2'd2) e_own = 1;
      m_st[a[2:0]] = 2'd2;
      m_data[a[2:0]] = d;
    end
    n_rd = 0; n_own = 0; n_wb = 0;
    while (!core_ready) @(negedge clk);
    core_valid = 1'b1; core_op = op; core_addr = a; core_wdata = d;
    @(negedge clk);
    core_valid = 1'b0;
    check(!core_ready, "R9 ready low while busy", core_ready, 0);
    while (!core_done) @(negedge clk);
    check(n_rd == e_rd, {rq, " read count"}, n_rd, e_rd);
    check(n_own == e_own, {rq, " ownership count"}, n_own, e_own);
    check(n_wb == e_wb, {rq, " writeback count"}, n_wb, e_wb);
    if (op == 2'd0 || op == 2'd2) check(core_rdata == e_data, {rq, " data"}, core_rdata, e_data);
  endtask

  task automatic fwd(input logic [7:0] a, input string rq);
    bit e_hit;
    e_hit = model_owns(a);
    @(negedge clk);
    fwd_valid = 1'b1; fwd_addr = a;
    @(negedge clk);
    fwd_valid = 1'b0;
    check(fwd_rsp_valid == 1'b1, {rq, " fwd valid"}, fwd_rsp_valid, 1);
    check(fwd_rsp_hit == e_hit, {rq, " fwd hit"}, fwd_rsp_hit, e_hit);
    if (e_hit) check(fwd_rsp_data == m_data[a[2:0]], {rq, " fwd data"}, fwd_rsp_data, m_data[a[2:0]]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      llc_mem[i] = 16'(i * 16'h0123 + 16'h5a);
      ref_mem[i] = llc_mem[i];
    end
    for (int i = 0; i < 4; i++) m_tag[i] = '0;
    for (int i = 0; i < 8; i++) begin m_st[i] = 2'd0; m_data[i] = '0; end
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(core_ready == 1'b1, "R1 ready after reset", core_ready, 1);
    check(llc_req_valid == 1'b0, "R1 no request after reset", llc_req_valid, 0);

    run_op(2'd0, 8'h10, 0, "R1 R2 first load misses");
    run_op(2'd0, 8'h10, 0, "R2 second load hits");
    run_op(2'd1, 8'h11, 16'hbeef, "R3 store takes ownership");
    run_op(2'd1, 8'h11, 16'hcafe, "R3 owned store local");
    run_op(2'd0, 8'h11, 0, "R3 load owned");
    poke(8'h10, 16'h7777);
    run_op(2'd0, 8'h10, 0, "R4 stale valid before sync");
    run_op(2'd2, 8'h02, 0, "R4 R6 acquire elsewhere");
    run_op(2'd0, 8'h10, 0, "R4 refetch after acquire");
    run_op(2'd0, 8'h11, 0, "R4 owned survives acquire");
    run_op(2'd3, 8'h11, 16'h1234, "R5 release on owned");
    run_op(2'd2, 8'h11, 0, "R5 acquire on owned");
    fwd(8'h11, "R8 owned");
    fwd(8'h10, "R8 not owned");
    run_op(2'd1, 8'h11, 16'h4321, "R8 still owned after forward");
    run_op(2'd1, 8'h10, 16'h0a0a, "R3 second word owned");
    run_op(2'd0, 8'h30, 0, "R7 evict two owned words");
    check(last_wb_addr == 8'h11, "R7 lowest word first", last_wb_addr, 8'h11);

    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      int r;
      a = 8'($urandom % 32);
      r = $urandom % 10;
      if (r < 3) run_op(2'd0, a, 0, "R2 R7 random load");
      else if (r < 6) run_op(2'd1, a, 16'($urandom), "R3 R7 random store");
      else if (r == 6) run_op(2'd2, a, 0, "R4 R5 random acquire");
      else if (r == 7) run_op(2'd3, a, 16'($urandom), "R4 R5 random release");
      else if (r == 8) poke(a, 16'($urandom));
      else fwd(a, "R8 random");
    end

    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 256; i++) if (llc_mem[i] !== ref_mem[i]) bad++;
      check(bad == 0, "R7 writeback contents", bad, 0);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule